// File: doc/BRIEF.md
# AES Host Buffer Sequencer

This block sits between a 32-bit register port and a 128-bit block-cipher core. Software (or a data mover acting for it) writes four 32-bit words into an input buffer, programs a 64-bit byte length and a mode word, and reads results back through the same addresses. The block hands a full 128-bit block to the core with a one-cycle start strobe. It keeps the returned block in an output buffer and reports completion.

The sequencer also tracks how much of the stream is left. The length counter drops by one block (16 bytes) per start and saturates at zero. The block decides whether to request more data or a new context. A zero length means "stream forever" in the unauthenticated modes and "nothing to do" in the authenticated ones. A readout window returns zeros while a block is in flight. After that it returns the tag first and then the IV, or only the IV when the mode makes no tag.

Register words are numbered: 0..3 data window, 4 length low half, 5 length high half, 6 mode, 8..11 IV (write) and tag/IV window (read). Word k of any 128-bit value occupies bits [32k+31:32k].

Top module: `aes_host_seq`

## Requirements
- R1: After reset, `done`, `ctx_req` and `core_start` are 0, `data_req` is 1, the length reads 0, the mode decodes as ECB, and the data window reads 0.
- R2: A write to address k (0..3) loads input word k; a read of address k returns word k of the last block received from the core, never the written input.
- R3: `core_start` is raised only once all four input words have been written since the previous start, in any order and with other accesses in between; `core_blk` word k then holds the last value written at address k.
- R4: `core_mode` follows mode-word bits 9..5 with priority 9 over 8 over 7 over 6 over 5: bit9 gives 5 (CCM), bit8 gives 4 (GCM), bit7 gives 3 (CBC-MAC), bit6 gives 2 (CTR), bit5 gives 1 (CBC); with none of them set (including all of bits 28:5 zero) it gives 0 (ECB). Codes 3..5 are the authenticated modes.
- R5: Each start lowers the 64-bit length (readable at addresses 4 and 5) by 16, saturating at 0 when fewer than 16 bytes remain.
- R6: When a start brings a nonzero length to 0, `ctx_req` rises and `data_req` falls; no start follows, even with a full buffer, until the length or mode is written.
- R7: In modes 0..2 with a programmed length of 0, blocks keep being started, the length stays 0 and `ctx_req` stays low.
- R8: In modes 3..5 with the length at 0, `data_req` is low and no start occurs.
- R9: Writing the mode word leaves the length unchanged.
- R10: While a block is in flight (from start until the core's result is taken), reads of addresses 8..11 return 0.
- R11: After an authenticated block completes, the window returns the tag until address 11 has been read, and the IV afterwards; in modes 0..2 it returns the IV.
- R12: `done` rises the cycle after `core_done` and falls after the next write to addresses 0..3.
- R13: No start is issued while `core_busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational on address |
| data_req | output | 1 | More input words are wanted |
| ctx_req | output | 1 | Stream ended; new length or mode wanted |
| done | output | 1 | Output buffer holds a fresh result |
| core_start | output | 1 | One-cycle block start to the core |
| core_mode | output | 3 | Decoded cipher mode |
| core_blk | output | 128 | Input block to the core |
| core_busy | input | 1 | Core cannot accept a block |
| core_done | input | 1 | Core result valid |
| core_dout | input | 128 | Core output block |
| core_tag | input | 128 | Core authentication tag |

## Verification
The input words are written in directed order and in random permutations, with length and tag-window reads in between. This shows whether the block assembles words by address rather than by arrival, and whether it starts only on the fourth distinct word. The length is driven through one-block, two-block, partial-block and zero values in both unauthenticated and authenticated modes. The results tell saturating decrement apart from endless streaming and from a stalled request. The tag window is read while a block is in flight, then in tag-then-IV order and in a tagless mode, which separates the three sources it can return.

// File: rtl/aes_hs_pkg.sv
package aes_hs_pkg;

  typedef enum logic [2:0] {
    CM_ECB    = 3'd0,
    CM_CBC    = 3'd1,
    CM_CTR    = 3'd2,
    CM_CBCMAC = 3'd3,
    CM_GCM    = 3'd4,
    CM_CCM    = 3'd5
  } cmode_e;

  localparam int unsigned ADR_LEN_LO = 4;
  localparam int unsigned ADR_LEN_HI = 5;
  localparam int unsigned ADR_MODE   = 6;
  localparam int unsigned ADR_TAGWIN = 8;

  // R4: priority decode of mode bits 9..5, anything else falls to ECB
  function automatic cmode_e decode_mode(input logic [4:0] sel);
    cmode_e m;
    if (sel[4])      m = CM_CCM;
    else if (sel[3]) m = CM_GCM;
    else if (sel[2]) m = CM_CBCMAC;
    else if (sel[1]) m = CM_CTR;
    else if (sel[0]) m = CM_CBC;
    else             m = CM_ECB;
    return m;
  endfunction

  function automatic logic is_auth(input cmode_e m);
    return (m == CM_CBCMAC) || (m == CM_GCM) || (m == CM_CCM);
  endfunction

endpackage

// File: rtl/aes_hs_inbuf.sv
module aes_hs_inbuf #(
  parameter int DW = 32,
  parameter int NW = 4,
  localparam int IW = $clog2(NW),
  localparam int BW = DW * NW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic [BW-1:0] blk,
  output logic          full
);

  logic [NW-1:0][DW-1:0] word_q, word_n;
  logic [NW-1:0]         seen_q, seen_n;

  always_comb begin
    word_n = word_q;
    seen_n = take ? '0 : seen_q;
    if (wr_en) begin
      word_n[wr_idx] = wr_data;
      seen_n[wr_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      seen_q <= '0;
    end else begin
      word_q <= word_n;
      seen_q <= seen_n;
    end
  end

  assign blk  = word_q;
  assign full = &seen_q;

  // R3: a block is taken only when every word has arrived
  a_r3_take_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full);

  // R3: a take empties the buffer unless a word lands in the same cycle
  a_r3_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !wr_en) |=> !full);

endmodule

// File: rtl/aes_hs_len.sv
module aes_hs_len #(
  parameter int DW   = 32,
  parameter int LW   = 64,
  parameter int STEP = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] wdata,
  input  logic          mode_wr,
  input  logic          dec,
  input  logic          basic,
  output logic [LW-1:0] len,
  output logic          exhausted,
  output logic          allowed
);

  localparam logic [LW-1:0] STEP_L = LW'(STEP);

  logic [LW-1:0] len_q, len_n;
  logic          exh_q, exh_n;

  always_comb begin
    len_n = len_q;
    exh_n = exh_q;
    if (dec && (len_q != '0)) begin
      len_n = (len_q > STEP_L) ? (len_q - STEP_L) : '0;
      if (len_n == '0) exh_n = 1'b1;
    end
    if (wr_lo) begin
      len_n[DW-1:0] = wdata;
      exh_n = 1'b0;
    end
    if (wr_hi) begin
      len_n[LW-1:DW] = wdata;
      exh_n = 1'b0;
    end
    if (mode_wr) exh_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      exh_q <= 1'b0;
    end else begin
      len_q <= len_n;
      exh_q <= exh_n;
    end
  end

  assign len       = len_q;
  assign exhausted = exh_q;
  assign allowed   = (len_q != '0) || (basic && !exh_q);

  // R5: a full block step subtracts exactly STEP
  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !wr_lo && !wr_hi && (len_q >= STEP_L)) |=> (len_q == $past(len_q) - STEP_L));

  // R6: an ended stream stays ended until a length or mode write
  a_r6_stays_ended: assert property (@(posedge clk) disable iff (!rst_n)
    (exh_q && !wr_lo && !wr_hi && !mode_wr) |=> (exh_q && (len_q == '0)));

  // R9: a mode write alone keeps the length
  a_r9_mode_keeps_len: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && !wr_lo && !wr_hi && !dec) |=> $stable(len_q));

endmodule

// File: rtl/aes_hs_tagwin.sv
module aes_hs_tagwin #(
  parameter int DW = 32,
  parameter int NW = 4,
  localparam int IW = $clog2(NW),
  localparam int BW = DW * NW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iv_wr,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  input  logic          load,
  input  logic [BW-1:0] tag_in,
  input  logic          has_tag,
  input  logic          rd,
  input  logic          busy,
  output logic [DW-1:0] rd_word
);

  logic [NW-1:0][DW-1:0] iv_q, iv_n;
  logic [BW-1:0]         tag_q, tag_n;
  logic                  pend_q, pend_n;
  logic                  last_rd;

  assign last_rd = rd && !busy && (idx == IW'(NW - 1));

  always_comb begin
    iv_n   = iv_q;
    tag_n  = tag_q;
    pend_n = pend_q;
    if (iv_wr) iv_n[idx] = wdata;
    if (load) begin
      tag_n  = tag_in;
      pend_n = has_tag;
    end else if (last_rd) begin
      pend_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iv_q   <= '0;
      tag_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      iv_q   <= iv_n;
      tag_q  <= tag_n;
      pend_q <= pend_n;
    end
  end

  always_comb begin
    if (busy)        rd_word = '0;
    else if (pend_q) rd_word = tag_q[DW*int'(idx) +: DW];
    else             rd_word = iv_q[idx];
  end

  // R11: reading the last tag word hands the window over to the IV
  a_r11_tag_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && last_rd && !load) |=> !pend_q);

endmodule

// File: rtl/aes_host_seq.sv
module aes_host_seq
  import aes_hs_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NW   = 4,
  parameter int LW   = 64,
  parameter int AW   = 4,
  localparam int IW  = $clog2(NW),
  localparam int BW  = DW * NW,
  localparam int BLK_BYTES = BW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          data_req,
  output logic          ctx_req,
  output logic          done,
  output logic          core_start,
  output logic [2:0]    core_mode,
  output logic [BW-1:0] core_blk,
  input  logic          core_busy,
  input  logic          core_done,
  input  logic [BW-1:0] core_dout,
  input  logic [BW-1:0] core_tag
);

  // address decode
  logic          sel_data, sel_tag, sel_lo, sel_hi, sel_mode;
  logic [IW-1:0] widx;

  assign widx     = reg_addr[IW-1:0];
  assign sel_data = (reg_addr < AW'(NW));
  assign sel_tag  = (reg_addr >= AW'(ADR_TAGWIN)) && (reg_addr < AW'(ADR_TAGWIN + NW));
  assign sel_lo   = (reg_addr == AW'(ADR_LEN_LO));
  assign sel_hi   = (reg_addr == AW'(ADR_LEN_HI));
  assign sel_mode = (reg_addr == AW'(ADR_MODE));

  // control state
  logic [DW-1:0] mode_q, mode_n;
  logic          active_q, active_n;
  logic          done_q, done_n;
  logic [BW-1:0] obuf_q, obuf_n;

  cmode_e        mode_dec;
  logic          basic;
  logic          buf_full;
  logic          len_ok;
  logic          len_end;
  logic [LW-1:0] len_val;
  logic [DW-1:0] tw_word;

  assign mode_dec = decode_mode(mode_q[9:5]);
  assign basic    = !is_auth(mode_dec);

  aes_hs_inbuf #(.DW(DW), .NW(NW)) u_inbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr && sel_data),
    .wr_idx  (widx),
    .wr_data (reg_wdata),
    .take    (core_start),
    .blk     (core_blk),
    .full    (buf_full)
  );

  aes_hs_len #(.DW(DW), .LW(LW), .STEP(BLK_BYTES)) u_len (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_lo     (reg_wr && sel_lo),
    .wr_hi     (reg_wr && sel_hi),
    .wdata     (reg_wdata),
    .mode_wr   (reg_wr && sel_mode),
    .dec       (core_start),
    .basic     (basic),
    .len       (len_val),
    .exhausted (len_end),
    .allowed   (len_ok)
  );

  aes_hs_tagwin #(.DW(DW), .NW(NW)) u_tagwin (
    .clk     (clk),
    .rst_n   (rst_n),
    .iv_wr   (reg_wr && sel_tag),
    .idx     (widx),
    .wdata   (reg_wdata),
    .load    (core_done && active_q),
    .tag_in  (core_tag),
    .has_tag (!basic),
    .rd      (reg_rd && sel_tag),
    .busy    (active_q),
    .rd_word (tw_word)
  );

  assign core_start = buf_full && len_ok && !active_q && !core_busy;
  assign core_mode  = mode_dec;
  assign data_req   = len_ok && !buf_full;
  assign ctx_req    = len_end;
  assign done       = done_q;

  always_comb begin
    mode_n   = mode_q;
    active_n = active_q;
    done_n   = done_q;
    obuf_n   = obuf_q;
    if (reg_wr && sel_mode) mode_n = reg_wdata;
    if (reg_wr && sel_data) done_n = 1'b0;
    if (core_start) begin
      active_n = 1'b1;
    end else if (core_done && active_q) begin
      active_n = 1'b0;
      done_n   = 1'b1;
      obuf_n   = core_dout;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
      obuf_q   <= '0;
    end else begin
      mode_q   <= mode_n;
      active_q <= active_n;
      done_q   <= done_n;
      obuf_q   <= obuf_n;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (sel_data)      reg_rdata = obuf_q[DW*int'(widx) +: DW];
    else if (sel_tag)  reg_rdata = tw_word;
    else if (sel_lo)   reg_rdata = len_val[DW-1:0];
    else if (sel_hi)   reg_rdata = len_val[LW-1:DW];
    else if (sel_mode) reg_rdata = mode_q;
  end

  // R13: no start into a busy core
  a_r13_wait_busy: assert property (@(posedge clk) disable iff (!rst_n)
    core_busy |-> !core_start);

  // R8: authenticated modes never start on a zero length
  a_r8_auth_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (core_start && !basic) |-> (len_val != '0));

  // R6: a pending context request blocks starts
  a_r6_ctx_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_req |-> !core_start);

  // R12: a taken result raises done
  a_r12_done_set: assert property (@(posedge clk) disable iff (!rst_n)
    (core_done && active_q) |=> done);

  // R10: the window is blank while a block is in flight
  a_r10_blank_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_tag && active_q) |-> (reg_rdata == '0));

endmodule

// File: tb/aes_host_seq_test.sv
`timescale 1ns/1ps
module aes_host_seq_test;

  localparam logic [127:0] XMASK = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;
  localparam int LAT = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         data_req, ctx_req, done, core_start;
  logic [2:0]   core_mode;
  logic [127:0] core_blk;
  logic         core_busy;
  logic         core_done;
  logic [127:0] core_dout, core_tag;

  logic         stub_busy, hold_busy = 1'b0;
  logic [127:0] cap;
  int           cnt;
  int           starts;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign core_busy = stub_busy | hold_busy;

  aes_host_seq uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .data_req(data_req), .ctx_req(ctx_req), .done(done),
    .core_start(core_start), .core_mode(core_mode), .core_blk(core_blk),
    .core_busy(core_busy), .core_done(core_done),
    .core_dout(core_dout), .core_tag(core_tag)
  );

  function automatic logic [127:0] f_out(input logic [127:0] b);
    return b ^ XMASK;
  endfunction

  function automatic logic [127:0] f_tag(input logic [127:0] b);
    return {b[63:0], b[127:64]};
  endfunction

  // behavioural core stub
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stub_busy <= 1'b0; core_done <= 1'b0; cnt <= 0; cap <= '0; starts <= 0;
    end else begin
      core_done <= 1'b0;
      if (core_start) begin
        cap <= core_blk; stub_busy <= 1'b1; cnt <= LAT; starts <= starts + 1;
      end else if (cnt == 1) begin
        core_done <= 1'b1; stub_busy <= 1'b0; cnt <= 0;
      end else if (cnt > 1) begin
        cnt <= cnt - 1;
      end
    end
  end
  assign core_dout = f_out(cap);
  assign core_tag  = f_tag(cap);

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 4'(a);
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 50; i++) begin
      if (done) break;
      @(negedge clk);
    end
  endtask

  task automatic put_block(input logic [127:0] b);
    for (int k = 0; k < 4; k++) wr(k, b[32*k +: 32]);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=%0d exp=0", 1);
    finish_run();
  end

  logic [31:0]  d;
  logic [127:0] b, iv;
  int           s0;

  initial begin
    void'($urandom(32'd2024));
    iv = 128'h11112222_33334444_55556666_77778888;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(done == 0 && ctx_req == 0 && core_start == 0, "R1 flags", {done, ctx_req, core_start}, 0);
    check(data_req == 1, "R1 data_req", data_req, 1);
    check(core_mode == 0, "R1 mode ECB", core_mode, 0);
    rd(4, d); check(d == 0, "R1 len", d, 0);
    rd(0, d); check(d == 0, "R1 data window", d, 0);

    for (int k = 0; k < 4; k++) wr(8 + k, iv[32*k +: 32]);

    // R3 R2 R5: two-block ECB stream, words out of order
    wr(4, 32);
    b = 128'hdeadbeef_01234567_89abcdef_cafef00d;
    s0 = starts;
    wr(3, b[127:96]); wr(1, b[63:32]);
    rd(4, d); check(d == 32, "R5 len before start", d, 32);
    wr(0, b[31:0]);
    repeat (3) @(negedge clk);
    check(starts == s0, "R3 no start on three words", starts, s0);
    wr(2, b[95:64]);
    wait_done();
    check(cap == b, "R3 assembled block", cap, b);
    check(done == 1, "R12 done set", done, 1);
    for (int k = 0; k < 4; k++) begin
      rd(k, d); check(d == f_out(b)[32*k +: 32], "R2 output window", d, f_out(b)[32*k +: 32]);
    end
    rd(4, d); check(d == 16, "R5 one step", d, 16);
    wr(0, 32'h0);
    check(done == 0, "R12 done cleared by word write", done, 0);

    // R6 end of stream
    wr(1, 0); wr(2, 0); wr(3, 0);
    wait_done();
    check(ctx_req == 1 && data_req == 0, "R6 ctx after end", {ctx_req, data_req}, 2'b10);
    rd(8, d); check(d == iv[31:0], "R11 ECB window gives IV", d, iv[31:0]);
    s0 = starts;
    put_block(128'h5);
    repeat (6) @(negedge clk);
    check(starts == s0, "R6 no start after end", starts, s0);

    // R7 R9: mode write reopens with zero length, endless stream in CBC
    wr(6, 32'h20);
    check(core_mode == 1, "R4 CBC code", core_mode, 1);
    wait_done();
    check(starts == s0 + 1, "R7 start after mode write", starts, s0 + 1);
    for (int n = 0; n < 3; n++) begin
      put_block(128'h100 + 128'(n));
      wait_done();
    end
    check(starts == s0 + 4, "R7 endless starts", starts, s0 + 4);
    rd(4, d); check(d == 0 && ctx_req == 0, "R7 len stays zero", {ctx_req, d}, 0);

    wr(4, 48);
    wr(6, 32'h40);
    check(core_mode == 2, "R4 CTR code", core_mode, 2);
    rd(4, d); check(d == 48, "R9 length kept", d, 48);
    wr(6, 32'h1fff_fc00);
    check(core_mode == 0, "R4 high bits only gives ECB", core_mode, 0);
    wr(6, 32'h2a0);
    check(core_mode == 5, "R4 priority CCM", core_mode, 5);

    // R13 busy holds start
    hold_busy = 1'b1;
    s0 = starts;
    put_block(128'h77);
    repeat (5) @(negedge clk);
    check(starts == s0, "R13 held by busy", starts, s0);
    hold_busy = 1'b0;
    wait_done();
    check(starts == s0 + 1, "R13 start after busy drops", starts, s0 + 1);

    // R8 R10 R11: GCM
    wr(4, 0);
    wr(6, 32'h100);
    check(data_req == 0, "R8 no data request", data_req, 0);
    s0 = starts;
    b = 128'hfeedface_0badf00d_13579bdf_2468ace0;
    put_block(b);
    repeat (5) @(negedge clk);
    check(starts == s0, "R8 no start at zero length", starts, s0);
    wr(4, 20);
    @(negedge clk);
    rd(9, d); check(d == 0, "R10 window zero in flight", d, 0);
    wait_done();
    rd(4, d); check(d == 4, "R5 partial remainder", d, 4);
    for (int k = 0; k < 4; k++) begin
      rd(8 + k, d); check(d == f_tag(b)[32*k +: 32], "R11 tag first", d, f_tag(b)[32*k +: 32]);
    end
    rd(8, d); check(d == iv[31:0], "R11 IV after tag", d, iv[31:0]);
    put_block(128'h9);
    wait_done();
    rd(4, d); check(d == 0 && ctx_req == 1, "R5 saturate to zero", {ctx_req, d}, {1'b1, 32'd0});

    // random: one-block streams in random modes, words in random order
    for (int it = 0; it < 24; it++) begin
      int perm[4];
      int m;
      logic [31:0] mw;
      logic auth;
      m = $urandom_range(5, 0);
      mw = (m == 0) ? 32'h0 : (32'h1 << (4 + m));
      auth = (m >= 3);
      wr(6, mw);
      wr(4, 16);
      b = {$urandom, $urandom, $urandom, $urandom};
      for (int i = 0; i < 4; i++) perm[i] = i;
      for (int i = 3; i > 0; i--) begin
        int j, t;
        j = $urandom_range(i, 0);
        t = perm[i]; perm[i] = perm[j]; perm[j] = t;
      end
      for (int i = 0; i < 4; i++) begin
        wr(perm[i], b[32*perm[i] +: 32]);
        if (i == 1) begin
          rd(4, d); check(d == 16, "R3 interleaved len read", d, 16);
        end
      end
      wait_done();
      check(cap == b, "R3 random block", cap, b);
      check(core_mode == 3'(m), "R4 random mode", core_mode, 3'(m));
      rd(perm[0], d); check(d == f_out(b)[32*perm[0] +: 32], "R2 random output", d, f_out(b)[32*perm[0] +: 32]);
      rd(11, d);
      check(d == (auth ? f_tag(b)[127:96] : iv[127:96]), "R11 random window", d,
            auth ? f_tag(b)[127:96] : iv[127:96]);
      rd(11, d); check(d == iv[127:96], "R11 random IV after", d, iv[127:96]);
      check(ctx_req == 1, "R6 random end", ctx_req, 1);
    end

    finish_run();
  end

endmodule